// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block holds the digital code that sets the strength of a set of output drivers. An external calibration source supplies a target code. The block moves its active code toward that target. It moves the code only in cycles when the data outputs are not driving the bus, so a code change never disturbs data while it is being transmitted.

Update opportunities come from two sources:
- cycles in which the bus is idle, such as writes or deselected cycles;
- cycles in which the output enable holds the drivers off across the clock edge.

When the calibration pin reads as open, or as tied to the I/O supply, the target is replaced by the maximum-impedance code.

The block also has a free-running power-up counter. It raises a completion flag once the fixed settling window has elapsed.

The code is stored in a plain register. The step decision comes from a small control module. The control module tells the datapath to step up, step down or hold through a two-bit strobe struct.

Top module: `imp_update_sched`

## Requirements
- R1: While reset is low and on the first cycle after it is released, the code output equals the all-ones value (maximum impedance) and the complete flag is 0.
- R2: On a clock edge where the bus-drive input is 1 and the output-disable input is 0, the code does not change.
- R3: On a permitted edge, where the effective target is above the code, the code rises by exactly one.
- R4: On a permitted edge, where the effective target is below the code, the code falls by exactly one.
- R5: On a permitted edge, where the code already equals the effective target, the code holds.
- R6: While the pin-float input is 1, the effective target is the all-ones code, whatever the target input says.
- R7: An edge where the output-disable input is 1 is permitted even when the bus-drive input is 1.
- R8: The complete flag is 0 after 4095 or fewer rising edges since reset release. It is 1 from the 4096th edge onward and never falls again until reset.
- R9: The code never moves by more than one step between consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| targetCode | input | CODE_W | Code requested by the calibration source |
| padFloat | input | 1 | 1 when the calibration pin is open or tied to the I/O supply |
| busDrive | input | 1 | 1 when a read is placing data on the bus in this cycle |
| outDisable | input | 1 | 1 when the output enable holds the drivers off around this edge |
| curCode | output | CODE_W | Active impedance code |
| calDone | output | 1 | Power-up settling window has elapsed |

## Verification
The properties assume that every input is synchronous to the clock and stable at the sampling edge. This includes the output-disable input, which must meet setup and hold to count as an update opportunity.

The properties also assume that the target code changes only between edges, never through one. The bench meets both conditions by driving all inputs on the falling edge.

The bench runs directed phases for hold, rise, fall, equality, pin float and output disable. It then runs a long random mix, which crosses the 4096-edge boundary of the complete flag.

// File: rtl/imp_sched_pkg.sv
package imp_sched_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } imp_step_t;
endpackage

// File: rtl/imp_warmup.sv
module imp_warmup #(
  parameter int WARMUP_CYCLES = 4096
) (
  input  logic clk,
  input  logic rstN,
  output logic calDone
);
  localparam int CNT_W = $clog2(WARMUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WARMUP_CYCLES);

  logic [CNT_W-1:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (edgeCnt != LIMIT) begin
      edgeCnt <= edgeCnt + CNT_W'(1);
    end
  end

  assign calDone = (edgeCnt == LIMIT);
endmodule

// File: rtl/imp_step_ctrl.sv
module imp_step_ctrl
  import imp_sched_pkg::*;
(
  input  logic      busDrive,
  input  logic      outDisable,
  input  logic      belowTgt,
  input  logic      aboveTgt,
  output imp_step_t step
);
  logic permit;

  // An update is allowed when the pads are not actively driving:
  // either no read is on the bus, or the enable holds the drivers off.
  assign permit = outDisable | ~busDrive;

  always_comb begin
    step          = '0;
    step.stepUp   = permit & belowTgt;
    step.stepDown = permit & aboveTgt;
  end
endmodule

// File: rtl/imp_code_path.sv
module imp_code_path
  import imp_sched_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              padFloat,
  input  imp_step_t         step,
  output logic [CODE_W-1:0] curCode,
  output logic              belowTgt,
  output logic              aboveTgt
);
  localparam logic [CODE_W-1:0] MAX_IMP = {CODE_W{1'b1}};

  logic [CODE_W-1:0] effTarget;

  assign effTarget = padFloat ? MAX_IMP : targetCode;
  assign belowTgt  = (curCode < effTarget);
  assign aboveTgt  = (curCode > effTarget);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCode <= MAX_IMP;
    end else if (step.stepUp) begin
      curCode <= curCode + CODE_W'(1);
    end else if (step.stepDown) begin
      curCode <= curCode - CODE_W'(1);
    end
  end
endmodule

// File: rtl/imp_update_sched.sv
module imp_update_sched
  import imp_sched_pkg::*;
#(
  parameter int CODE_W        = 6,
  parameter int WARMUP_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              padFloat,
  input  logic              busDrive,
  input  logic              outDisable,
  output logic [CODE_W-1:0] curCode,
  output logic              calDone
);
  imp_step_t step;
  logic      belowTgt;
  logic      aboveTgt;

  imp_step_ctrl u_ctrl (
    .busDrive  (busDrive),
    .outDisable(outDisable),
    .belowTgt  (belowTgt),
    .aboveTgt  (aboveTgt),
    .step      (step)
  );

  imp_code_path #(.CODE_W(CODE_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .targetCode(targetCode),
    .padFloat  (padFloat),
    .step      (step),
    .curCode   (curCode),
    .belowTgt  (belowTgt),
    .aboveTgt  (aboveTgt)
  );

  imp_warmup #(.WARMUP_CYCLES(WARMUP_CYCLES)) u_warm (
    .clk    (clk),
    .rstN   (rstN),
    .calDone(calDone)
  );
endmodule

// File: rtl/imp_update_sched_chk.sv
module imp_update_sched_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] targetCode,
  input logic              padFloat,
  input logic              busDrive,
  input logic              outDisable,
  input logic [CODE_W-1:0] curCode,
  input logic              calDone
);
  localparam logic [CODE_W-1:0] MAX_IMP = {CODE_W{1'b1}};

  // R2
  driven_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && !outDisable) |=> $stable(curCode));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (curCode == $past(curCode) ||
              curCode == $past(curCode) + CODE_W'(1) ||
              curCode == $past(curCode) - CODE_W'(1)));

  // R3
  rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!busDrive || outDisable) && !padFloat && curCode < targetCode)
      |=> curCode == $past(curCode) + CODE_W'(1));

  // R6
  float_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!busDrive || outDisable) && padFloat && curCode != MAX_IMP)
      |=> curCode == $past(curCode) + CODE_W'(1));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    calDone |=> calDone);
endmodule

bind imp_update_sched imp_update_sched_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .targetCode(targetCode),
  .padFloat  (padFloat),
  .busDrive  (busDrive),
  .outDisable(outDisable),
  .curCode   (curCode),
  .calDone   (calDone)
);

// File: tb/tb_imp_update_sched.sv
module tb_imp_update_sched;
  localparam int CODE_W = 6;
  localparam int WARM   = 4096;
  localparam int MAXC   = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CODE_W-1:0] targetCode = '0;
  logic              padFloat = 1'b0;
  logic              busDrive = 1'b0;
  logic              outDisable = 1'b0;
  logic [CODE_W-1:0] curCode;
  logic              calDone;

  int checks = 0;
  int errors = 0;
  int modelCode = MAXC;
  int modelCnt = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  imp_update_sched #(.CODE_W(CODE_W), .WARMUP_CYCLES(WARM)) dut (
    .clk(clk), .rstN(rstN), .targetCode(targetCode), .padFloat(padFloat),
    .busDrive(busDrive), .outDisable(outDisable),
    .curCode(curCode), .calDone(calDone)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, advance the model at the rising edge,
  // compare at the following falling edge.
  task automatic cyc(input string tag, input int tgt, input bit pf,
                     input bit bd, input bit od);
    int eff;
    targetCode = CODE_W'(tgt);
    padFloat   = pf;
    busDrive   = bd;
    outDisable = od;
    @(posedge clk);
    eff = pf ? MAXC : tgt;
    if (od || !bd) begin
      if (modelCode < eff) modelCode++;
      else if (modelCode > eff) modelCode--;
    end
    if (modelCnt < WARM) modelCnt++;
    @(negedge clk);
    check(tag, int'(curCode), modelCode);
    check("R8", int'(calDone), (modelCnt >= WARM) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(curCode), MAXC);
    check("R1", int'(calDone), 0);
    rstN = 1'b1;
    // first edge after release: still held at maximum impedance by bus drive
    cyc("R1", 10, 0, 1, 0);
    for (int i = 0; i < 20; i++) cyc("R2", 10, 0, 1, 0);
    for (int i = 0; i < 60; i++) cyc("R4", 10, 0, 0, 0);
    for (int i = 0; i < 15; i++) cyc("R5", 10, 0, 0, 0);
    for (int i = 0; i < 35; i++) cyc("R3", 40, 0, 0, 0);
    for (int i = 0; i < 60; i++) cyc("R6", 0, 1, 0, 0);
    for (int i = 0; i < 70; i++) cyc("R7", 5, 0, 1, 1);
    for (int i = 0; i < 4500; i++)
      cyc("R9", int'($urandom_range(MAXC, 0)), ($urandom_range(7, 0) == 0),
          ($urandom_range(1, 0) == 1), ($urandom_range(3, 0) == 0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected 200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule